// File: doc/BRIEF.md
# Oversampled Jitter Code Encoder

This block turns the comparator outputs of four timing-measurement units into timing-difference codes and sends them off-chip on two serial pins. Each unit presents 16 comparator bits, and the number of ones among them is that unit's reading. A two-bit mode input selects how the four readings are combined. In the 4X mode every unit samples its own clock phase and reports its own code. In the 2X mode the units form two chained pairs. In the 1X mode all four units form one chain whose range is four times that of a single unit.

A valid strobe captures the comparator vectors and the mode together. The block then shifts the resulting codes out, MSB first, on the two data pins in parallel. A marker pin is high on the first bit of each frame. A new capture is accepted while the block is idle, or in the cycle that carries a frame's last bit. This lets frames run back to back with no gap.

Top module: `jit_osmp_encoder`

## Requirements
- R1: A unit's reading is the number of ones in its 16-bit comparator slice, wherever those ones sit. Unit k occupies cmp_i[16k+15:16k].
- R2: mode_i encoding: 0 selects 4X, 1 selects 2X, and both 2 and 3 select 1X.
- R3: In 4X mode, four 6-bit codes are produced, one per unit. Each code equals that unit's reading, except that a unit with all 16 bits set reports 15.
- R4: In 2X mode, units 0/1 form pair A and units 2/3 form pair B. A pair's code is the lower unit's reading if that unit is not saturated. Otherwise it is 16 plus the upper unit's reading if the upper unit is not saturated. A pair with both units saturated reports 31.
- R5: In 1X mode, the code is 16·i plus the reading of unit i, where i is the lowest-numbered unit that is not saturated. If all four units are saturated, the code is 63.
- R6: Frames are sent MSB first, one bit per cycle on each pin. In 4X mode a frame is 12 cycles long: pin 0 carries unit 0's code then unit 1's code, and pin 1 carries unit 2's code then unit 3's code. In 2X mode a frame is 6 cycles long, with pair A on pin 0 and pair B on pin 1. In 1X mode a frame is 6 cycles long, with the code on pin 0 and pin 1 held at 0.
- R7: The first bit of a frame appears in the cycle after the clock edge that accepts valid_i. frame_o is high during that first bit only.
- R8: valid_i is ignored while a frame is in progress, except in the frame's last bit cycle. Changes to cmp_i or mode_i after the accepting edge do not alter the frame being sent.
- R9: A valid_i that is high during a frame's last bit cycle starts the next frame in the following cycle, with no idle gap.
- R10: After reset and whenever no frame is being sent, sd_o is 0 and frame_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Capture strobe for cmp_i and mode_i |
| mode_i | input | 2 | Oversampling mode select |
| cmp_i | input | 64 | Comparator bits of the four units, unit 0 in the low bits |
| sd_o | output | 2 | Serial data pins |
| frame_o | output | 1 | High on the first bit of each frame |

## Verification
The 4X mode is swept with all seventeen reading values in rotated unit patterns. These patterns separate the clamp on a saturated unit from an ordinary count, and show a mix-up between pins or between slots. The 2X mode is swept over every pair of readings, which covers each branch of the pair chaining: lower unit live, lower unit saturated, and both units saturated. The 1X mode is swept over every saturated prefix length with every following reading, so the 16-unit offsets and the all-saturated maximum are each checked. Other cases cover rotated, non-thermometer comparator patterns, mode code 3, strobes arriving mid-frame while the inputs change, and strobes arriving on a frame's last bit. These tell correct capture and chaining apart from live-input leaks, dropped frames and extra frames.

// File: rtl/jit_enc_pkg.sv
package jit_enc_pkg;
  localparam int unsigned NUM_UNITS = 4;

  typedef enum logic [1:0] {
    OSR_4X     = 2'd0,
    OSR_2X     = 2'd1,
    OSR_1X     = 2'd2,
    OSR_1X_ALT = 2'd3
  } osr_mode_e;
endpackage

// File: rtl/jit_unit_count.sv
module jit_unit_count #(
  parameter int unsigned CMP_BITS = 16,
  localparam int unsigned CNT_W = $clog2(CMP_BITS + 1)
) (
  input  logic [CMP_BITS-1:0] cmp_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                sat_o
);
  always_comb begin
    cnt_o = '0;
    for (int b = 0; b < CMP_BITS; b++) cnt_o = cnt_o + CNT_W'(cmp_i[b]);
  end

  assign sat_o = &cmp_i;
endmodule

// File: rtl/jit_code_combine.sv
module jit_code_combine
  import jit_enc_pkg::*;
#(
  parameter int unsigned CMP_BITS = 16,
  localparam int unsigned CNT_W  = $clog2(CMP_BITS + 1),
  localparam int unsigned CODE_W = $clog2(NUM_UNITS * CMP_BITS)
) (
  input  logic [NUM_UNITS-1:0][CNT_W-1:0]    cnt_i,
  input  logic [NUM_UNITS-1:0]               sat_i,
  output logic [NUM_UNITS-1:0][CODE_W-1:0]   solo_o,
  output logic [NUM_UNITS/2-1:0][CODE_W-1:0] pair_o,
  output logic [CODE_W-1:0]                  wide_o
);
  // lowest non-saturated unit in [lo, lo+n) wins; full chain reports its max
  function automatic logic [CODE_W-1:0] chain_code(
    input logic [NUM_UNITS-1:0][CNT_W-1:0] c,
    input logic [NUM_UNITS-1:0]            s,
    input int                              lo,
    input int                              n
  );
    logic [CODE_W-1:0] r;
    r = CODE_W'(n * CMP_BITS - 1);
    for (int j = n - 1; j >= 0; j--)
      if (!s[lo+j]) r = CODE_W'(j * CMP_BITS) + CODE_W'(c[lo+j]);
    return r;
  endfunction

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_solo
    assign solo_o[k] = chain_code(cnt_i, sat_i, k, 1);
  end

  for (genvar p = 0; p < NUM_UNITS / 2; p++) begin : g_pair
    assign pair_o[p] = chain_code(cnt_i, sat_i, 2 * p, 2);
  end

  assign wide_o = chain_code(cnt_i, sat_i, 0, NUM_UNITS);
endmodule

// File: rtl/jit_frame_ser.sv
module jit_frame_ser
  import jit_enc_pkg::*;
#(
  parameter int unsigned CODE_W = 6,
  localparam int unsigned SH_W  = 2 * CODE_W,
  localparam int unsigned POS_W = $clog2(SH_W)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               valid_i,
  input  osr_mode_e                          mode_i,
  input  logic [NUM_UNITS-1:0][CODE_W-1:0]   solo_i,
  input  logic [NUM_UNITS/2-1:0][CODE_W-1:0] pair_i,
  input  logic [CODE_W-1:0]                  wide_i,
  output logic [1:0]                         sd_o,
  output logic                               frame_o
);
  logic             busy_q;
  logic [POS_W-1:0] pos_q, len_m1_q;
  logic [SH_W-1:0]  sh0_q, sh1_q;
  logic [SH_W-1:0]  ld0, ld1;
  logic [POS_W-1:0] ld_len_m1;
  logic             last_bit, accept;

  assign last_bit = busy_q && (pos_q == len_m1_q);
  assign accept   = valid_i && (!busy_q || last_bit);

  always_comb begin
    unique case (mode_i)
      OSR_4X: begin
        ld0       = {solo_i[0], solo_i[1]};
        ld1       = {solo_i[2], solo_i[3]};
        ld_len_m1 = POS_W'(SH_W - 1);
      end
      OSR_2X: begin
        ld0       = {pair_i[0], {CODE_W{1'b0}}};
        ld1       = {pair_i[1], {CODE_W{1'b0}}};
        ld_len_m1 = POS_W'(CODE_W - 1);
      end
      default: begin
        ld0       = {wide_i, {CODE_W{1'b0}}};
        ld1       = '0;
        ld_len_m1 = POS_W'(CODE_W - 1);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      pos_q    <= '0;
      len_m1_q <= '0;
      sh0_q    <= '0;
      sh1_q    <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      pos_q    <= '0;
      len_m1_q <= ld_len_m1;
      sh0_q    <= ld0;
      sh1_q    <= ld1;
    end else if (last_bit) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      sh0_q  <= '0;
      sh1_q  <= '0;
    end else if (busy_q) begin
      pos_q <= pos_q + POS_W'(1);
      sh0_q <= {sh0_q[SH_W-2:0], 1'b0};
      sh1_q <= {sh1_q[SH_W-2:0], 1'b0};
    end
  end

  assign sd_o    = {sh1_q[SH_W-1], sh0_q[SH_W-1]};
  assign frame_o = busy_q && (pos_q == '0);

  AST_ACCEPT_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> frame_o); // R7
  AST_MARK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (sd_o == 2'b00) && !frame_o); // R10
  AST_LEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_bit) |=> $stable(len_m1_q)); // R8
  AST_1X_PIN1_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (mode_i == OSR_1X || mode_i == OSR_1X_ALT)) |=> !sd_o[1]); // R6
endmodule

// File: rtl/jit_osmp_encoder.sv
module jit_osmp_encoder
  import jit_enc_pkg::*;
#(
  parameter int unsigned CMP_BITS = 16,
  localparam int unsigned CNT_W  = $clog2(CMP_BITS + 1),
  localparam int unsigned CODE_W = $clog2(NUM_UNITS * CMP_BITS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [1:0]                    mode_i,
  input  logic [NUM_UNITS*CMP_BITS-1:0] cmp_i,
  output logic [1:0]                    sd_o,
  output logic                          frame_o
);
  logic [NUM_UNITS-1:0][CNT_W-1:0]    cnt;
  logic [NUM_UNITS-1:0]               sat;
  logic [NUM_UNITS-1:0][CODE_W-1:0]   solo;
  logic [NUM_UNITS/2-1:0][CODE_W-1:0] pair;
  logic [CODE_W-1:0]                  wide;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    jit_unit_count #(.CMP_BITS(CMP_BITS)) u_count (
      .cmp_i (cmp_i[k*CMP_BITS +: CMP_BITS]),
      .cnt_o (cnt[k]),
      .sat_o (sat[k])
    );
  end

  jit_code_combine #(.CMP_BITS(CMP_BITS)) u_combine (
    .cnt_i  (cnt),
    .sat_i  (sat),
    .solo_o (solo),
    .pair_o (pair),
    .wide_o (wide)
  );

  jit_frame_ser #(.CODE_W(CODE_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .mode_i  (osr_mode_e'(mode_i)),
    .solo_i  (solo),
    .pair_i  (pair),
    .wide_i  (wide),
    .sd_o    (sd_o),
    .frame_o (frame_o)
  );

  AST_WIDE_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sat[0]) |-> (wide == CODE_W'(cnt[0]))); // R5
endmodule

// File: tb/jit_osmp_encoder_bench.sv
module jit_osmp_encoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni, valid_i;
  logic [1:0]  mode_i;
  logic [63:0] cmp_i;
  logic [1:0]  sd_o;
  logic        frame_o;
  int          n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  jit_osmp_encoder u_jit_osmp_encoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .cmp_i(cmp_i), .sd_o(sd_o), .frame_o(frame_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] slice(input int n, input int rot);
    logic [15:0] t;
    t = (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    return 16'((t << rot) | (t >> (16 - rot)));
  endfunction

  function automatic int solo(input int n);
    return (n >= 16) ? 15 : n;
  endfunction

  function automatic int chain(input int c[4], input int lo, input int n);
    int r = n * 16 - 1;
    for (int j = n - 1; j >= 0; j--) if (c[lo+j] < 16) r = j * 16 + c[lo+j];
    return r;
  endfunction

  function automatic logic [63:0] pack(input int c[4], input int rot);
    return {slice(c[3], (rot * 3) % 16), slice(c[2], (rot * 2) % 16),
            slice(c[1], rot % 16), slice(c[0], 0)};
  endfunction

  // at a negedge: present inputs, let one posedge accept them, return at next negedge
  task automatic launch(input int m, input int c[4], input int rot);
    mode_i  = 2'(m);
    cmp_i   = pack(c, rot);
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    cmp_i   = ~cmp_i;     // R8: later input changes must not reach the frame
    mode_i  = 2'(3 - m);
  endtask

  // at a negedge showing the first bit; returns at the negedge of the last bit
  task automatic read_frame(input int m, input int c[4], input string req, input int inj);
    int len, e0, e1, w0, w1;
    bit mark_ok;
    if (m == 0) begin
      len = 12; e0 = (solo(c[0]) << 6) | solo(c[1]); e1 = (solo(c[2]) << 6) | solo(c[3]);
    end else if (m == 1) begin
      len = 6; e0 = chain(c, 0, 2); e1 = chain(c, 2, 2);
    end else begin
      len = 6; e0 = chain(c, 0, 4); e1 = 0;
    end
    w0 = 0; w1 = 0; mark_ok = 1'b1;
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk_i);
      if (frame_o !== (i == 0)) mark_ok = 1'b0;
      w0 = (w0 << 1) | int'(sd_o[0]);
      w1 = (w1 << 1) | int'(sd_o[1]);
      if (inj >= 0) begin
        valid_i = (i == inj);
        cmp_i   = {$urandom(), $urandom()};
        mode_i  = 2'd0;
      end
    end
    check(mark_ok && w0 == e0 && w1 == e1, req, (w0 << 12) | w1, (e0 << 12) | e1);
  endtask

  task automatic idle_check(input string req);
    @(negedge clk_i);
    check(sd_o == 2'b00 && frame_o == 1'b0, req, {sd_o, frame_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c[4];
    rst_ni = 1'b0; valid_i = 1'b0; mode_i = 2'd0; cmp_i = '0;
    repeat (3) @(negedge clk_i);
    check(sd_o == 2'b00 && frame_o == 1'b0, "R10 reset", {sd_o, frame_o}, 0);
    rst_ni = 1'b1;
    idle_check("R10 idle");

    // R3 R1 R6 R7: 4X sweep, rotated slices
    for (int v = 0; v <= 16; v++) begin
      c = '{v, (v + 5) % 17, (v + 11) % 17, 16 - v};
      launch(0, c, v);
      read_frame(0, c, "R3 4X", -1);
      idle_check("R10 gap");
    end

    // R4 R9: 2X sweep, frames back to back
    @(negedge clk_i);
    for (int a = 0; a <= 16; a++)
      for (int b = 0; b <= 16; b++) begin
        c = '{a, b, b, a};
        launch(1, c, a + b);
        read_frame(1, c, "R4 R9 2X", -1);
      end
    idle_check("R10 after burst");

    // R5: 1X, every saturated prefix and following reading
    for (int k = 0; k <= 4; k++)
      for (int n = 0; n <= 16; n++) begin
        for (int u = 0; u < 4; u++) c[u] = (u < k) ? 16 : (u == k ? n : (n + k) % 17);
        launch(2, c, n);
        read_frame(2, c, "R5 1X", -1);
        if (k == 4) break;
      end

    // R2: mode code 3 behaves as 1X
    for (int n = 0; n <= 16; n += 4) begin
      c = '{16, 16, n, 3};
      launch(3, c, 1);
      read_frame(3, c, "R2 mode3", -1);
    end

    // R8: strobe mid-frame with junk inputs is ignored; no frame follows
    c = '{7, 16, 0, 12};
    @(negedge clk_i);
    launch(0, c, 5);
    read_frame(0, c, "R8 4X mid-strobe", 4);
    idle_check("R8 no extra frame");
    c = '{16, 9, 16, 16};
    launch(1, c, 2);
    read_frame(1, c, "R8 2X mid-strobe", 2);
    idle_check("R8 no extra frame");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule